// File: doc/BRIEF.md
# Early-terminating Booth multiply-accumulate unit

This block is the multiply engine of a 32-bit RISC core. It runs 32x32 multiply, 32-bit multiply-accumulate, and signed or unsigned long (64-bit) multiply with an optional 64-bit accumulate. Multiplier bits are recoded as radix-4 Booth digits in the range -2..+2. Each digit's partial product goes into a carry-save pair made of a sum vector and a carry vector. One clock retires four digits, which is eight multiplier bits. Iteration stops as soon as the multiplier bits not yet consumed are only extension bits.

The core raises `start` for one cycle while the unit is idle. It presents the operation code, both operands, the accumulator and a set-flags request at the same time. `busy` then stays high for a number of cycles that depends on the operand. The cycle after `busy` falls, `done` pulses with the result. The negative and zero flags follow the result in the usual way. The carry flag takes the value that the multiplier's internal carry-save state produces. It is neither cleared nor preserved, so software that depends on the post-multiply carry sees the value a hardware array of this shape would give.

Operation codes on `op`: 000 multiply, 001 multiply-accumulate, 010 unsigned long, 011 unsigned long accumulate, 100 signed long, 101 signed long accumulate.

Top module: `mac_booth_et`

## Requirements
- R1: For op 000 the result is the low 32 bits of mcand*mult. For op 001 it is the low 32 bits of mcand*mult + acc[31:0]. In both cases result[63:32] is zero.
- R2: For ops 010/011 the result is the 64-bit unsigned product (plus acc for 011). For ops 100/101 it is the 64-bit signed product (plus acc for 101), modulo 2^64.
- R3: Let n be the Booth cycle count. n is the smallest k in 1..3 for which mult[31:8k] is all zeros or all ones, and 4 if no such k exists. busy stays high for n cycles, plus one more cycle when the op accumulates or is long.
- R4: For unsigned long ops (010, 011), only all-zero upper bits shorten n. All-ones upper bits do not.
- R5: start is accepted only while busy is low, and busy is high in the next cycle. A start while busy is ignored: it produces no extra done and does not alter the running result.
- R6: done is high for exactly one cycle, in the first cycle after busy falls. While done is high, busy is low and result holds the completed value.
- R7: With flags requested, flag_n is the top result bit (bit 31 for 32-bit ops, bit 63 for long ops). flag_z is 1 exactly when the 32-bit result (or the 64-bit result for long ops) is zero.
- R8: flags_valid equals done when set_flags was 1 at start and stays low otherwise. flag_n, flag_z and flag_c keep their previous values when flags were not requested.
- R9: The carry-save model starts with S preloaded with the accumulator (acc[31:0] zero-extended for op 001, zero for 000 and non-accumulate long ops) and K = 0. Step j (0..4n-1) uses digit d = -2*m[2j+1] + m[2j] + m[2j-1], with m[-1] = 0 and m extended past bit 31 with its sign (zeros for unsigned long). It forms A = (d*M) << 2j mod 2^64, where M is mcand sign-extended (zero-extended for unsigned long). Then S <= S^K^A and K <= majority(S,K,A) << 1. When n < 4, flag_c = K[31].
- R10: For 32-bit ops with n = 4, flag_c is 1 exactly when mult[31:30] = 2'b10.
- R11: For long ops with n = 4, flag_c = K[63] of the R9 carry vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, honoured only when idle |
| op | input | 3 | Operation code |
| set_flags | input | 1 | Update N/Z/C for this operation |
| mcand | input | 32 | Multiplicand |
| mult | input | 32 | Multiplier; its value sets the cycle count |
| acc | input | 64 | Accumulator (low word only for 32-bit accumulate) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Product or sum; upper word zero for 32-bit ops |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag from the carry-save state |
| flags_valid | output | 1 | Flags were updated by this completion |

## Verification
The hardest cases to reach from the ports are two. The first is a long operation that runs all four Booth cycles, where the carry comes from bit 63 of the internal carry vector. The second is the boundary where the bits above a threshold are uniform but the bit just below differs in sign. Uniform random operands almost never stop early, and they almost never sit on such an edge. The stimulus therefore builds each multiplier from a random low field of 8, 16 or 24 bits and fills everything above it with all zeros or all ones. It mixes these with fully random multipliers across all six operation codes. Directed cases add 0x80000000, 0xBFFFFFFF, all-ones with unsigned long ops, and a second start while busy.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      OP_MUL   = 3'b000,
      OP_MLA   = 3'b001,
      OP_UMULL = 3'b010,
      OP_UMLAL = 3'b011,
      OP_SMULL = 3'b100,
      OP_SMLAL = 3'b101
   } mac_op_e;

   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_sel_t;

   // Radix-4 digit select from window {b(2j+1), b(2j), b(2j-1)}
   function automatic booth_sel_t booth_decode(input logic [2:0] w);
      booth_sel_t s;
      s.neg = w[2];
      s.one = w[1] ^ w[0];
      s.two = (w[2] & ~w[1] & ~w[0]) | (~w[2] & w[1] & w[0]);
      return s;
   endfunction

endpackage

// File: rtl/mac_booth_row.sv
module mac_booth_row
   import mac_pkg::*;
#(
   parameter int W     = 64,
   parameter int SHIFT = 0
) (
   input  logic [W-1:0] s_in,
   input  logic [W-1:0] k_in,
   input  logic [W-1:0] mc,
   input  logic [2:0]   win,
   output logic [W-1:0] s_out,
   output logic [W-1:0] k_out
);

   booth_sel_t   sel;
   logic [W-1:0] mag;
   logic [W-1:0] addend;

   always_comb begin
      sel    = booth_decode(win);
      mag    = sel.two ? (mc << 1) : (sel.one ? mc : '0);
      addend = (sel.neg ? (~mag + 1'b1) : mag) << SHIFT;
      s_out  = s_in ^ k_in ^ addend;
      k_out  = ((s_in & k_in) | (s_in & addend) | (k_in & addend)) << 1;
   end

endmodule

// File: rtl/mac_term_ctl.sv
module mac_term_ctl #(
   parameter int XLEN = 32,
   parameter int BPC  = 8,
   parameter int NCYC = 4,
   parameter int CW   = 3
) (
   input  logic [XLEN-1:0] mult,
   input  logic            zero_only,
   output logic [CW-1:0]   ncyc
);

   logic [NCYC-1:0] stop;

   assign stop[0] = 1'b0;

   for (genvar k = 1; k < NCYC; k++) begin : g_thr
      assign stop[k] = ~|mult[XLEN-1:k*BPC] |
                       (~zero_only & (&mult[XLEN-1:k*BPC]));
   end

   always_comb begin
      ncyc = CW'(NCYC);
      for (int k = NCYC - 1; k >= 1; k--) begin
         if (stop[k]) ncyc = CW'(k);
      end
   end

endmodule

// File: rtl/mac_booth_et.sv
module mac_booth_et
   import mac_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int STEPS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              set_flags,
   input  logic [XLEN-1:0]   mcand,
   input  logic [XLEN-1:0]   mult,
   input  logic [2*XLEN-1:0] acc,
   output logic              busy,
   output logic              done,
   output logic [2*XLEN-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flags_valid
);

   localparam int PW   = 2 * XLEN;
   localparam int BPC  = 2 * STEPS;
   localparam int NCYC = XLEN / BPC;
   localparam int CW   = $clog2(NCYC + 2);
   localparam int MW   = XLEN + 1;

   if (XLEN % BPC != 0) begin : g_bad_div
      $error("XLEN must be a multiple of 2*STEPS");
   end
   if (BPC > XLEN || XLEN < 2) begin : g_bad_size
      $error("STEPS too large for XLEN");
   end

   // decode at launch
   logic is_long, is_uns, is_acc;
   logic [CW-1:0] ncyc;

   assign is_long = op[2] ^ op[1];
   assign is_uns  = (op[2:1] == 2'b01);
   assign is_acc  = op[0];

   mac_term_ctl #(.XLEN(XLEN), .BPC(BPC), .NCYC(NCYC), .CW(CW)) u_term (
      .mult      (mult),
      .zero_only (is_uns),
      .ncyc      (ncyc)
   );

   // datapath state
   logic [PW-1:0] s_q, k_q, mc_q;
   logic [MW-1:0] m_q;
   logic          ext_q;
   logic [CW-1:0] left_q;
   logic          xtra_q, long_q, full_q, topc_q, sf_q;

   logic          stepping, last;
   logic [PW-1:0] s_nx, k_nx, mc_nx, s_fx, k_fx, sum;
   logic [MW-1:0] m_nx;

   logic [PW-1:0] s_ch [STEPS+1];
   logic [PW-1:0] k_ch [STEPS+1];

   assign s_ch[0] = s_q;
   assign k_ch[0] = k_q;

   for (genvar i = 0; i < STEPS; i++) begin : g_row
      mac_booth_row #(.W(PW), .SHIFT(2*i)) u_row (
         .s_in  (s_ch[i]),
         .k_in  (k_ch[i]),
         .mc    (mc_q),
         .win   (m_q[2*i+2:2*i]),
         .s_out (s_ch[i+1]),
         .k_out (k_ch[i+1])
      );
   end

   assign busy     = (|left_q) | xtra_q;
   assign stepping = |left_q;
   assign last     = ((left_q == CW'(1)) & ~xtra_q) | ((left_q == '0) & xtra_q);

   assign s_nx  = stepping ? s_ch[STEPS] : s_q;
   assign k_nx  = stepping ? k_ch[STEPS] : k_q;
   assign mc_nx = stepping ? (mc_q << BPC) : mc_q;
   assign m_nx  = stepping ? {{BPC{ext_q}}, m_q[MW-1:BPC]} : m_q;

   // extension digit left over by early stop (or unsigned top bit)
   mac_booth_row #(.W(PW), .SHIFT(0)) u_fix (
      .s_in  (s_nx),
      .k_in  (k_nx),
      .mc    (mc_nx),
      .win   (m_nx[2:0]),
      .s_out (s_fx),
      .k_out (k_fx)
   );

   assign sum = s_fx + k_fx;

   logic          c_val;
   logic [PW-1:0] res_val;

   always_comb begin
      if (long_q) begin
         res_val = sum;
         c_val   = full_q ? k_nx[PW-1] : k_nx[XLEN-1];
      end else begin
         res_val = {{XLEN{1'b0}}, sum[XLEN-1:0]};
         c_val   = full_q ? topc_q : k_nx[XLEN-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q <= '0; k_q <= '0; mc_q <= '0; m_q <= '0; ext_q <= 1'b0;
         left_q <= '0; xtra_q <= 1'b0; long_q <= 1'b0; full_q <= 1'b0;
         topc_q <= 1'b0; sf_q <= 1'b0;
         done <= 1'b0; flags_valid <= 1'b0; result <= '0;
         flag_n <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0;
      end else if (start && !busy) begin
         s_q    <= !is_acc ? '0 : (is_long ? acc : {{XLEN{1'b0}}, acc[XLEN-1:0]});
         k_q    <= '0;
         mc_q   <= {{XLEN{~is_uns & mcand[XLEN-1]}}, mcand};
         m_q    <= {mult, 1'b0};
         ext_q  <= ~is_uns & mult[XLEN-1];
         left_q <= ncyc;
         xtra_q <= is_acc | is_long;
         long_q <= is_long;
         full_q <= (ncyc == CW'(NCYC));
         topc_q <= (mult[XLEN-1:XLEN-2] == 2'b10);
         sf_q   <= set_flags;
         done   <= 1'b0;
         flags_valid <= 1'b0;
      end else begin
         s_q  <= s_nx;
         k_q  <= k_nx;
         mc_q <= mc_nx;
         m_q  <= m_nx;
         if (stepping)    left_q <= left_q - 1'b1;
         else if (xtra_q) xtra_q <= 1'b0;
         done        <= last;
         flags_valid <= last & sf_q;
         if (last) begin
            result <= res_val;
            if (sf_q) begin
               flag_n <= long_q ? res_val[PW-1] : res_val[XLEN-1];
               flag_z <= long_q ? (res_val == '0) : (res_val[XLEN-1:0] == '0);
               flag_c <= c_val;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   logic [CW:0] bcnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    bcnt_q <= '0;
      else if (busy) bcnt_q <= bcnt_q + 1'b1;
      else           bcnt_q <= '0;
   end

   // R5
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   fell_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt_q <= (CW+1)'(NCYC)));

   // R8
   fv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_valid |-> done);

   // R8
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_valid |-> ($stable(flag_n) && $stable(flag_z) && $stable(flag_c)));

endmodule

// File: tb/mac_booth_et_tb.sv
module mac_booth_et_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'b000;
   logic        set_flags = 1'b0;
   logic [31:0] mcand = '0;
   logic [31:0] mult = '0;
   logic [63:0] acc = '0;
   logic        busy, done, flag_n, flag_z, flag_c, flags_valid;
   logic [63:0] result;

   always #2 clk = ~clk;

   mac_booth_et dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .set_flags(set_flags),
      .mcand(mcand), .mult(mult), .acc(acc), .busy(busy), .done(done),
      .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
      .flags_valid(flags_valid)
   );

   typedef struct {
      logic [63:0] res;
      logic        n, z, c, sf, lng, uns;
      int          cyc;
      string       ctag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_bad = 0, n_push = 0, n_done = 0;
   logic ln = 1'b0, lz = 1'b0, lc = 1'b0;
   bit   finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // Reference model built from the requirement text
   function automatic exp_t model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                                  input logic [63:0] ac);
      exp_t e;
      bit lng, uns, acf;
      logic [63:0] mc, mb, pa, s, kv, ns, ad, prod;
      logic signed [63:0] t;
      int n, d, b1, b0, bm;
      lng = o[2] ^ o[1];
      uns = (o[2:1] == 2'b01);
      acf = o[0];
      mc  = uns ? {32'b0, a} : {{32{a[31]}}, a};
      mb  = uns ? {32'b0, b} : {{32{b[31]}}, b};
      pa  = !acf ? 64'b0 : (lng ? ac : {32'b0, ac[31:0]});
      n = 4;
      for (int k = 3; k >= 1; k--) begin
         if ((b >> (8*k)) == 32'b0) n = k;
         else if (!uns && ((b >> (8*k)) == (32'hFFFF_FFFF >> (8*k)))) n = k;
      end
      s = pa; kv = '0;
      for (int j = 0; j < 4*n; j++) begin
         b1 = int'(mb[2*j+1]);
         b0 = int'(mb[2*j]);
         bm = (j == 0) ? 0 : int'(mb[2*j-1]);
         d  = -2*b1 + b0 + bm;
         t  = $signed(mc) * 64'(signed'(d));
         ad = 64'(t) << (2*j);
         ns = s ^ kv ^ ad;
         kv = ((s & kv) | (s & ad) | (kv & ad)) << 1;
         s  = ns;
      end
      prod  = mc * mb + pa;
      e.res = lng ? prod : {32'b0, prod[31:0]};
      e.lng = lng;
      e.uns = uns;
      e.cyc = n + ((acf || lng) ? 1 : 0);
      if (n == 4) begin
         if (lng) begin e.c = kv[63]; e.ctag = "R11"; end
         else     begin e.c = (b[31:30] == 2'b10); e.ctag = "R10"; end
      end else begin
         e.c = kv[31]; e.ctag = "R9";
      end
      e.n = lng ? e.res[63] : e.res[31];
      e.z = lng ? (e.res == 64'b0) : (e.res[31:0] == 32'b0);
      return e;
   endfunction

   // Driver: push expectation, launch, optionally poke start while busy
   task automatic run(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] ac, input bit sf, input bit poke);
      exp_t e;
      while (busy) @(negedge clk);
      e = model(o, a, b, ac);
      e.sf = sf;
      if (sf) begin ln = e.n; lz = e.z; lc = e.c; end
      else    begin e.n = ln; e.z = lz; e.c = lc; end
      q.push_back(e);
      n_push++;
      op = o; mcand = a; mult = b; acc = ac; set_flags = sf; start = 1'b1;
      @(negedge clk);
      if (poke) begin
         // R5: second start while busy must be ignored
         op = 3'b101; mcand = 32'h1234_5678; mult = 32'hFFFF_0001; acc = '1; set_flags = ~sf;
         @(negedge clk);
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   // Monitor: count busy cycles, compare at done
   int bcnt = 0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (!done) check(!flags_valid, "R8 flags_valid without done", 64'(flags_valid), 64'd0);
         if (done) begin
            exp_t e;
            n_done++;
            if (q.size() == 0) begin
               check(1'b0, "R5 unexpected done", 64'd1, 64'd0);
            end else begin
               e = q.pop_front();
               check(result === e.res, e.lng ? "R2 result" : "R1 result", result, e.res);
               check(bcnt == e.cyc, e.uns ? "R4 busy cycles" : "R3 busy cycles", 64'(bcnt), 64'(e.cyc));
               check(!busy, "R6 busy low at done", 64'(busy), 64'd0);
               check(flags_valid == e.sf, "R8 flags_valid", 64'(flags_valid), 64'(e.sf));
               check(flag_n == e.n, e.sf ? "R7 flag_n" : "R8 flag_n hold", 64'(flag_n), 64'(e.n));
               check(flag_z == e.z, e.sf ? "R7 flag_z" : "R8 flag_z hold", 64'(flag_z), 64'(e.z));
               check(flag_c == e.c, e.sf ? e.ctag : "R8 flag_c hold", 64'(flag_c), 64'(e.c));
            end
            bcnt = 0;
         end else if (busy) begin
            bcnt++;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 R6 reset state
      check(!busy && !done, "R6 reset busy/done", {62'b0, busy, done}, 64'd0);
      check(result == 64'b0 && !flags_valid, "R5 reset result", result, 64'd0);

      run(3'b000, 32'd7,         32'd9,         64'd0, 1'b1, 1'b0);   // R3 one cycle
      run(3'b000, 32'hFFFF_FFFF, 32'h0000_01FF, 64'd0, 1'b1, 1'b0);   // R3 two cycles
      run(3'b000, 32'h1357_9BDF, 32'hFFFF_FF80, 64'd0, 1'b1, 1'b0);   // all-ones upper
      run(3'b000, 32'h1357_9BDF, 32'hFFFF_FF7F, 64'd0, 1'b1, 1'b0);   // bit below differs
      run(3'b000, 32'h0000_0003, 32'h8000_0000, 64'd0, 1'b1, 1'b0);   // R10 C=1
      run(3'b000, 32'h0000_0003, 32'hBFFF_FFFF, 64'd0, 1'b1, 1'b0);   // R10
      run(3'b000, 32'h0000_0003, 32'h4000_0000, 64'd0, 1'b1, 1'b0);   // R10 C=0
      run(3'b001, 32'h8000_0001, 32'h00FF_0000, 64'hDEAD_0000_0000_0005, 1'b1, 1'b0);
      run(3'b000, 32'h1234_5678, 32'd0,         64'd0, 1'b1, 1'b0);   // R7 zero
      run(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b1, 1'b0);   // R4 R11
      run(3'b010, 32'hFFFF_FFFF, 32'h0000_00FF, 64'd0, 1'b1, 1'b0);   // R4 short
      run(3'b011, 32'h8765_4321, 32'hFFFF_FF00, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
      run(3'b100, 32'h8000_0000, 32'hFFFF_FFFF, 64'd0, 1'b1, 1'b0);   // R2 signed
      run(3'b101, 32'h7FFF_FFFF, 32'h8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
      run(3'b100, 32'hC000_0000, 32'h7654_3210, 64'd0, 1'b0, 1'b0);   // R8 hold
      run(3'b001, 32'h0000_0002, 32'h0123_4567, 64'd77, 1'b1, 1'b1);  // R5 poke
      run(3'b011, 32'h0000_0005, 32'h0000_0003, 64'h0000_0001_0000_0000, 1'b0, 1'b1);

      for (int i = 0; i < 400; i++) begin
         logic [2:0]  o;
         logic [31:0] a, b, msk;
         logic [63:0] ac;
         int k;
         o  = 3'($urandom % 6);
         a  = $urandom;
         ac = {$urandom, $urandom};
         b  = $urandom;
         k  = int'($urandom % 4) + 1;
         if (k < 4) begin
            msk = (32'h1 << (8*k)) - 1;
            b   = b & msk;
            if ($urandom % 2 == 1) b = b | ~msk;
         end
         run(o, a, b, ac, ($urandom % 4) != 0, ($urandom % 8) == 0);
      end

      while (busy) @(negedge clk);
      repeat (5) @(negedge clk);
      check(q.size() == 0, "R5 pending expectations", 64'(q.size()), 64'd0);
      check(n_done == n_push, "R5 done count", 64'(n_done), 64'(n_push));
      summary();
   end

endmodule